// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash model. It watches the write cycles on the host bus and looks for a fixed handshake: two unlock writes with set data at set addresses, then a command byte. The commands it decodes switch the read path between the memory array and an identifier window, and start a program operation. For a program operation it captures the target address and data of the write that follows and sends a one-cycle start pulse to the program/erase controller.

An input pin selects byte-wide or word-wide addressing. The unlock and command addresses differ between the two modes. Only the low twelve address bits in use in each mode are compared. While the identifier window is open, a read returns a manufacturer code, a device code or the protect status of a block, depending on the two lowest word-address bits. Per-block protect flags are loaded through a side port. A parameter selects the boot variant. A controller input that reports an erase in progress or suspended blocks the return to array mode.

The bus address is byte-granular. `busAddr[0]` is the byte-select line below the word address, and `busAddr[k+1]` is word-address bit k. Bits `[12:1]` are therefore word bits 0 to 11, bits `[2:1]` are word bits 1:0, and bits `[19:13]` are the block number.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write of AAh is the first unlock step when the address matches. In byte mode (`byteMode`=1) the match is `busAddr[11:0]`=AAAh. In word mode the match is `busAddr[12:1]`=555h.
- R2: Directly after the first unlock step, a write of 55h is the second unlock step when the address matches. In byte mode the match is `busAddr[11:0]`=555h. In word mode the match is `busAddr[12:1]`=2AAh.
- R3: Address bits above the compared field have no effect on whether an unlock or command step matches. These are `busAddr[19:12]` in byte mode, and `busAddr[19:13]` plus `busAddr[0]` in word mode.
- R4: A write of F0h clears `autoSel` in the cycle after the write. F0h is accepted at any address, either on its own while idle or as the third write after both unlock steps.
- R5: While `eraseActive` is 1, a write of F0h leaves `autoSel` unchanged.
- R6: After both unlock steps, a write of 90h at the first-unlock address of the current mode sets `autoSel` in the cycle after the write.
- R7: Whenever `autoSel` is 1, `idData` depends on `busAddr[2:1]`. The value 00 gives 20h. The value 01 gives EEh when TOP_BOOT=1, or EFh when TOP_BOOT=0. The value 11 gives 00h.
- R8: Whenever `autoSel` is 1 and `busAddr[2:1]`=10, `idData` is 01h if the block `busAddr[19:13]` is protected, and 00h otherwise. A protect flag is written by `protWe` with `protBlk` and `protVal`, and takes effect in the next cycle. Reset clears every flag.
- R9: After both unlock steps, a write of A0h at the first-unlock address arms a program operation. The next write of any address and data raises `pgmStart` for exactly the following cycle. During that cycle, `pgmAddr` and `pgmData` hold the address and data of that write.
- R10: A write that does not match the expected step returns the decoder to idle. It leaves `autoSel` unchanged and raises no `pgmStart`, and a fresh first unlock step is then needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteMode | input | 1 | 1 selects byte-wide, 0 selects word-wide addressing |
| busWe | input | 1 | One-cycle write strobe |
| busAddr | input | ADDR_W+1 | Byte-granular bus address; bit 0 is the byte-select line |
| busData | input | 8 | Write data |
| eraseActive | input | 1 | Erase running or suspended; blocks F0h |
| protWe | input | 1 | Protect flag write enable |
| protBlk | input | BLK_W | Block number for the protect write |
| protVal | input | 1 | Protect flag value |
| autoSel | output | 1 | Read path shows the identifier window instead of the array |
| idData | output | 8 | Identifier or protect-status byte for the current address |
| pgmStart | output | 1 | One-cycle start pulse toward the controller |
| pgmAddr | output | ADDR_W+1 | Captured program address |
| pgmData | output | 8 | Captured program data |

## Verification
The assertions assume that a write strobe lasts one clock, that `busData` is stable while it is high, and that `eraseActive` changes only at a clock edge. The stimulus drives every input one nanosecond after a rising edge and drops `busWe` after a single cycle, so each write is seen exactly once. The identifier checks compare `idData` with the address present in the same cycle, so the bench keeps the address steady through every compare point.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_UNL2,
    SEQ_PGM
  } seqState_t;

  typedef struct packed {
    logic enterAuto;
    logic leaveAuto;
    logic startPgm;
  } cmdStrobe_t;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busWe,
  input  logic [7:0] busData,
  input  logic       hitUnl1,
  input  logic       hitUnl2,
  input  logic       eraseActive,
  output cmdStrobe_t strobe
);

  seqState_t seqState, seqNext;

  always_ff @(posedge clk) begin
    if (!rst_n) seqState <= SEQ_IDLE;
    else        seqState <= seqNext;
  end

  always_comb begin
    seqNext = seqState;
    strobe  = '0;
    if (busWe) begin
      seqNext = SEQ_IDLE;
      unique case (seqState)
        SEQ_IDLE: begin
          if (busData == CMD_RESET)
            strobe.leaveAuto = !eraseActive;
          else if (busData == CMD_UNLOCK_A && hitUnl1)
            seqNext = SEQ_UNL1;
        end
        SEQ_UNL1: begin
          if (busData == CMD_UNLOCK_B && hitUnl2)
            seqNext = SEQ_UNL2;
        end
        SEQ_UNL2: begin
          if (busData == CMD_RESET)
            strobe.leaveAuto = !eraseActive;
          else if (hitUnl1 && busData == CMD_IDENT)
            strobe.enterAuto = 1'b1;
          else if (hitUnl1 && busData == CMD_PROGRAM)
            seqNext = SEQ_PGM;
        end
        SEQ_PGM: strobe.startPgm = 1'b1;
        default: seqNext = SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLK_W    = 7,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteMode,
  input  logic [ADDR_W:0]   busAddr,
  input  logic [7:0]        busData,
  input  cmdStrobe_t        strobe,
  input  logic              protWe,
  input  logic [BLK_W-1:0]  protBlk,
  input  logic              protVal,
  output logic              hitUnl1,
  output logic              hitUnl2,
  output logic              autoSel,
  output logic [7:0]        idData,
  output logic              pgmStart,
  output logic [ADDR_W:0]   pgmAddr,
  output logic [7:0]        pgmData
);

  localparam int NUM_BLK = 1 << BLK_W;
  localparam int BLK_LO  = ADDR_W + 1 - BLK_W;
  localparam int CMP_W   = 12;
  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'hEE : 8'hEF;

  logic [CMP_W-1:0] cmpField;
  logic [CMP_W-1:0] keyUnl1, keyUnl2;
  logic [NUM_BLK-1:0] protBits;

  // byte mode compares from the byte-select line up, word mode from word bit 0
  always_comb begin
    if (byteMode) begin
      cmpField = busAddr[CMP_W-1:0];
      keyUnl1  = 12'hAAA;
      keyUnl2  = 12'h555;
    end else begin
      cmpField = busAddr[CMP_W:1];
      keyUnl1  = 12'h555;
      keyUnl2  = 12'h2AA;
    end
  end

  assign hitUnl1 = (cmpField == keyUnl1);
  assign hitUnl2 = (cmpField == keyUnl2);

  always_ff @(posedge clk) begin
    if (!rst_n)      protBits <= '0;
    else if (protWe) protBits[protBlk] <= protVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                autoSel <= 1'b0;
    else if (strobe.enterAuto) autoSel <= 1'b1;
    else if (strobe.leaveAuto) autoSel <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgmStart <= 1'b0;
      pgmAddr  <= '0;
      pgmData  <= '0;
    end else begin
      pgmStart <= strobe.startPgm;
      if (strobe.startPgm) begin
        pgmAddr <= busAddr;
        pgmData <= busData;
      end
    end
  end

  always_comb begin
    unique case (busAddr[2:1])
      2'b00:   idData = MFR_CODE;
      2'b01:   idData = DEV_CODE;
      2'b10:   idData = {7'b0, protBits[busAddr[ADDR_W:BLK_LO]]};
      default: idData = 8'h00;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLK_W    = 7,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byteMode,
  input  logic             busWe,
  input  logic [ADDR_W:0]  busAddr,
  input  logic [7:0]       busData,
  input  logic             eraseActive,
  input  logic             protWe,
  input  logic [BLK_W-1:0] protBlk,
  input  logic             protVal,
  output logic             autoSel,
  output logic [7:0]       idData,
  output logic             pgmStart,
  output logic [ADDR_W:0]  pgmAddr,
  output logic [7:0]       pgmData
);

  cmdStrobe_t strobe;
  logic hitUnl1, hitUnl2;

  fcd_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .busWe       (busWe),
    .busData     (busData),
    .hitUnl1     (hitUnl1),
    .hitUnl2     (hitUnl2),
    .eraseActive (eraseActive),
    .strobe      (strobe)
  );

  fcd_datapath #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .TOP_BOOT (TOP_BOOT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .byteMode (byteMode),
    .busAddr  (busAddr),
    .busData  (busData),
    .strobe   (strobe),
    .protWe   (protWe),
    .protBlk  (protBlk),
    .protVal  (protVal),
    .hitUnl1  (hitUnl1),
    .hitUnl2  (hitUnl2),
    .autoSel  (autoSel),
    .idData   (idData),
    .pgmStart (pgmStart),
    .pgmAddr  (pgmAddr),
    .pgmData  (pgmData)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 19
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busWe,
  input logic [ADDR_W:0] busAddr,
  input logic [7:0]      busData,
  input logic            eraseActive,
  input logic            autoSel,
  input logic [7:0]      idData,
  input logic            pgmStart,
  input logic [7:0]      pgmData
);

  assert_start_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pgmStart |-> $past(busWe));

  assert_start_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pgmStart |-> (pgmData == $past(busData)));

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pgmStart |=> !pgmStart);

  assert_reset_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(autoSel) |-> ($past(busData) == 8'hF0 && !$past(eraseActive)));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busWe) |-> ($stable(autoSel) && !pgmStart));

  assert_mfr_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (autoSel && busAddr[2:1] == 2'b00) |-> (idData == 8'h20));

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/100ps
module sim_flash_cmd_decoder;

  localparam int AW = 19;
  localparam int BW = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic byteMode = 1;
  logic busWe = 0;
  logic [AW:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic eraseActive = 0;
  logic protWe = 0;
  logic [BW-1:0] protBlk = '0;
  logic protVal = 0;
  logic autoSel, pgmStart;
  logic [7:0] idData, pgmData;
  logic [AW:0] pgmAddr;

  flash_cmd_decoder u0 (.*);

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R4 reset";

  // behavioural reference model
  int step = 0;
  bit mAuto = 0, mStart = 0;
  logic [AW:0] mAddr = '0;
  logic [7:0] mData = '0;
  bit mProt [128];

  function automatic bit isKey1(logic [AW:0] a, bit bm);
    if (bm) return a[11:0] == 12'hAAA;
    return a[12:1] == 12'h555;
  endfunction
  function automatic bit isKey2(logic [AW:0] a, bit bm);
    if (bm) return a[11:0] == 12'h555;
    return a[12:1] == 12'h2AA;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      step = 0; mAuto = 0; mStart = 0;
      foreach (mProt[i]) mProt[i] = 0;
    end else begin
      mStart = 0;
      if (protWe) mProt[protBlk] = protVal;
      if (busWe) begin
        case (step)
          0: begin
            if (busData == 8'hF0) begin if (!eraseActive) mAuto = 0; end
            else if (busData == 8'hAA && isKey1(busAddr, byteMode)) step = 1;
          end
          1: step = (busData == 8'h55 && isKey2(busAddr, byteMode)) ? 2 : 0;
          2: begin
            step = 0;
            if (busData == 8'hF0) begin if (!eraseActive) mAuto = 0; end
            else if (isKey1(busAddr, byteMode) && busData == 8'h90) mAuto = 1;
            else if (isKey1(busAddr, byteMode) && busData == 8'hA0) step = 3;
          end
          default: begin
            step = 0; mStart = 1; mAddr = busAddr; mData = busData;
          end
        endcase
      end
    end
  end

  function automatic logic [7:0] expId(logic [AW:0] a);
    case (a[2:1])
      2'b00: return 8'h20;
      2'b01: return 8'hEE;
      2'b10: return {7'b0, mProt[a[AW:13]]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("autoSel", autoSel, mAuto);
      check("pgmStart", pgmStart, mStart);
      if (mStart) begin
        check("pgmAddr", pgmAddr, mAddr);
        check("pgmData", pgmData, mData);
      end
      if (mAuto) check("idData", idData, expId(busAddr));
    end
  end

  task automatic wr(logic [AW:0] a, logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busData = d; busWe = 1;
    @(posedge clk); #1;
    busWe = 0;
  endtask

  task automatic rd(logic [AW:0] a);
    @(posedge clk); #1;
    busAddr = a;
    @(posedge clk);
  endtask

  task automatic prot(int blk, bit v);
    @(posedge clk); #1;
    protWe = 1; protBlk = blk[BW-1:0]; protVal = v;
    @(posedge clk); #1;
    protWe = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // byte-mode auto-select entry
    curReq = "R1 R2 R6"; byteMode = 1;
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h55); wr(20'h00AAA, 8'h90);
    curReq = "R7";
    rd(20'h00000); rd(20'h00002); rd(20'h00006); rd(20'h7A000);
    curReq = "R8";
    prot(5, 1);
    rd(20'h0A004); rd(20'h0C004); rd(20'hFE004);
    prot(5, 0); rd(20'h0A004);

    // read/reset alone
    curReq = "R4"; wr(20'h12345, 8'hF0); rd(20'h0);

    // word mode with high bits set
    curReq = "R3 R1 R2 R6"; byteMode = 0;
    wr(20'hFEAAB, 8'hAA); wr(20'h80555, 8'h55); wr(20'h40AAA, 8'h90);
    rd(20'h00002);
    curReq = "R5"; eraseActive = 1;
    wr(20'h0, 8'hF0); rd(20'h0);
    wr(20'h00AAA, 8'hAA); wr(20'h00554, 8'h55); wr(20'h00AAA, 8'hF0);
    eraseActive = 0;
    curReq = "R4"; wr(20'h00AAA, 8'hAA); wr(20'h00554, 8'h55); wr(20'h00AAA, 8'hF0);

    // byte-mode address used in word mode must not unlock
    curReq = "R1 R10";
    wr(20'h01AAA, 8'hAA); wr(20'h00554, 8'h55); wr(20'h00AAA, 8'h90);

    // mismatches
    curReq = "R10"; byteMode = 1;
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h56); wr(20'h00AAA, 8'h90);
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h55); wr(20'h00AAB, 8'h90);
    wr(20'h00AAA, 8'hAA); wr(20'h00556, 8'h55); wr(20'h00AAA, 8'hA0); wr(20'h00100, 8'h11);
    wr(20'h00AAA, 8'hAB); wr(20'h00555, 8'h55);

    // program in both modes
    curReq = "R9";
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h55); wr(20'h00AAA, 8'hA0);
    wr(20'h12345, 8'h3C); rd(20'h0);
    byteMode = 0;
    wr(20'h00AAA, 8'hAA); wr(20'h00554, 8'h55); wr(20'h00AAB, 8'hA0);
    wr(20'hFFFFF, 8'hAA); rd(20'h0);
    // the program data write of AAh must not start an unlock
    curReq = "R9 R10"; wr(20'h00554, 8'h55); wr(20'h00AAA, 8'h90);

    repeat (4) @(posedge clk);
    summary();
  end

endmodule